// File: doc/BRIEF.md
# Audio Codec Interrupt Status and Page Select Register

This block is one 16-bit control and status word in the register file of an audio codec that sits on a serial link. It collects interrupt events from two sources: a pulse meaning that the jack-sense engine has finished a sense cycle, and a pulse meaning that a GPIO input has changed. It keeps a sticky interrupt flag and a cause code that is frozen at the first event. When software enables it, it drives an interrupt level toward the link's GPI status slot. Software clears the flag by writing a one to it.

The same word starts sense cycles. When the sense-supported strap is high, writing a one to the sense bit issues a one-cycle start pulse to the sense engine. The bit then reads as busy until the sense-done pulse comes back. The low nibble holds a page index that the surrounding register file uses to pick which bank of paged registers is visible.

Reads are combinational from the stored state. All writes and events take effect at the next rising clock edge.

Top module: `audio_irq_page_reg`

## Requirements
- R1: After reset, rd_data reads 16'h0000, and link_irq, sense_start and page_sel are all 0.
- R2: A pulse on ev_sense_done or ev_gpio_chg sets the flag at bit 15 whatever the state of the enable bit. The cause code at bits 14:13 then reads 01 for a sense completion and 10 for a GPIO change.
- R3: Writing 1 to bit 15 clears the flag and returns the cause code to 00. Writing 0 to bit 15 leaves both unchanged. An event in the same cycle as a clearing write wins: the flag stays set and the cause code takes that event's code.
- R4: While the flag stays set, later events do not change the cause code. Two events in the same cycle with the flag clear latch the code 11.
- R5: link_irq equals the flag while the enable bit (bit 11, read/write) is 1, and is 0 while the enable bit is 0.
- R6: With sense_supported high and no cycle running, writing 1 to bit 12 gives a single-cycle sense_start pulse after the write edge. Bit 12 then reads 1 until a sense-done pulse clears it. A write of 1 to bit 12 while it reads 1 gives no new pulse.
- R7: With sense_supported low, writing 1 to bit 12 gives no sense_start pulse and bit 12 keeps reading 0.
- R8: Bits 3:0 are read/write, every write loads them, and page_sel shows their value.
- R9: Bits 10:4 always read 0. Writes to bits 14:13 do not change the cause code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register value |
| ev_sense_done | input | 1 | One-cycle pulse: sense cycle completed |
| ev_gpio_chg | input | 1 | One-cycle pulse: GPIO input changed |
| sense_supported | input | 1 | Strap: sense engine present |
| sense_start | output | 1 | One-cycle pulse that starts a sense cycle |
| page_sel | output | 4 | Selected register page |
| link_irq | output | 1 | Interrupt level toward the link status slot |

## Verification
Every stored result sits one register stage from its stimulus: flag, cause, enable, page and busy bit all change at the first rising edge after a write or an event pulse. link_irq follows from that stored state with no further delay. sense_start is itself a register, so it is high for exactly the cycle after the write edge and low one cycle later. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It samples at that second falling edge, where exactly one rising edge has passed. For the pulse it samples once more a cycle later to confirm that the pulse has ended.

// File: rtl/audio_irq_page_reg.sv
module audio_irq_page_reg #(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  input  logic              ev_sense_done,
  input  logic              ev_gpio_chg,
  input  logic              sense_supported,
  output logic              sense_start,
  output logic [PAGE_W-1:0] page_sel,
  output logic              link_irq
);
  localparam int RSV_W = 11 - PAGE_W;

  logic              flag, irq_en, busy;
  logic [1:0]        cause;
  logic [PAGE_W-1:0] page;

  wire any_ev    = ev_sense_done | ev_gpio_chg;
  wire clr       = wr_en & wr_data[15];
  wire start_req = wr_en & wr_data[12] & sense_supported & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag        <= 1'b0;
      cause       <= 2'b00;
      irq_en      <= 1'b0;
      busy        <= 1'b0;
      page        <= '0;
      sense_start <= 1'b0;
    end else begin
      if (any_ev)    flag <= 1'b1;
      else if (clr)  flag <= 1'b0;

      if (any_ev && (!flag || clr)) cause <= {ev_gpio_chg, ev_sense_done};
      else if (clr && !any_ev)      cause <= 2'b00;

      if (wr_en) begin
        irq_en <= wr_data[11];
        page   <= wr_data[PAGE_W-1:0];
      end

      if (start_req)          busy <= 1'b1;
      else if (ev_sense_done) busy <= 1'b0;

      sense_start <= start_req;
    end
  end

  assign rd_data  = {flag, cause, busy, irq_en, {RSV_W{1'b0}}, page};
  assign page_sel = page;
  assign link_irq = flag & irq_en;
endmodule

// File: rtl/audio_irq_page_reg_chk.sv
module audio_irq_page_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        ev_sense_done,
  input logic        ev_gpio_chg,
  input logic        sense_supported,
  input logic        sense_start,
  input logic        link_irq
);
  assert_event_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sense_done || ev_gpio_chg) |=> rd_data[15]);

  assert_clear_drops_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15] && !ev_sense_done && !ev_gpio_chg) |=> (rd_data[15:13] == 3'b000));

  assert_cause_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15] && !(wr_en && wr_data[15])) |=> $stable(rd_data[14:13]));

  assert_flag_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15] |-> (rd_data[14:13] != 2'b00));

  assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_irq |-> (rd_data[11] && rd_data[15]));

  assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sense_start |=> !sense_start);

  assert_start_marks_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sense_start |-> rd_data[12]);

  assert_no_start_unsupported_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_supported |=> !sense_start);

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[10:4] == 7'd0);
endmodule

bind audio_irq_page_reg audio_irq_page_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .ev_sense_done(ev_sense_done), .ev_gpio_chg(ev_gpio_chg),
  .sense_supported(sense_supported), .sense_start(sense_start), .link_irq(link_irq)
);

// File: tb/tb_audio_irq_page_reg.sv
`timescale 1ns/1ps
module tb_audio_irq_page_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic        ev_sense_done = 1'b0;
  logic        ev_gpio_chg = 1'b0;
  logic        sense_supported = 1'b0;
  logic        sense_start;
  logic [3:0]  page_sel;
  logic        link_irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  audio_irq_page_reg dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_sense_done(ev_sense_done), .ev_gpio_chg(ev_gpio_chg),
    .sense_supported(sense_supported), .sense_start(sense_start),
    .page_sel(page_sel), .link_irq(link_irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [15:0] d, input logic s, input logic g);
    @(negedge clk);
    wr_en = we; wr_data = d; ev_sense_done = s; ev_gpio_chg = g;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 16'h0; ev_sense_done = 1'b0; ev_gpio_chg = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_data", rd_data, 16'h0000);
    chk("R1 outputs", {13'd0, link_irq, sense_start, page_sel != 0}, 16'h0);
    rst_n = 1'b1;

    for (int p = 0; p < 16; p++) begin
      cyc(1'b1, 16'(p), 1'b0, 1'b0);
      chk("R8 page_sel", {12'd0, page_sel}, 16'(p));
      chk("R8 rd_data", rd_data, 16'(p));
    end

    for (int en = 0; en < 2; en++)
      for (int first = 1; first < 4; first++)
        for (int second = 0; second < 4; second++) begin
          logic [15:0] ctl;
          ctl = 16'(en << 11) | 16'h0003;
          cyc(1'b1, ctl | 16'h8000, 1'b0, 1'b0);
          chk("R3 cleared", rd_data, ctl);
          cyc(1'b0, 16'h0, first[0], first[1]);
          chk("R2/R4 first cause", rd_data, ctl | 16'h8000 | 16'(first << 13));
          chk("R5 link_irq", {15'd0, link_irq}, 16'(en));
          cyc(1'b0, 16'h0, second[0], second[1]);
          chk("R4 frozen", rd_data, ctl | 16'h8000 | 16'(first << 13));
          cyc(1'b1, ctl | 16'h6000, 1'b0, 1'b0);
          chk("R3/R9 write0 and cause write ignored", rd_data, ctl | 16'h8000 | 16'(first << 13));
          cyc(1'b1, ctl | 16'h8000, second[0], second[1]);
          chk("R3 event vs clear", rd_data,
              (second == 0) ? ctl : (ctl | 16'h8000 | 16'(second << 13)));
          chk("R5 link after clear", {15'd0, link_irq}, 16'((second != 0) && en == 1));
        end

    cyc(1'b1, 16'h8000, 1'b0, 1'b0);
    sense_supported = 1'b1;
    cyc(1'b1, 16'h1000, 1'b0, 1'b0);
    chk("R6 start pulse", {15'd0, sense_start}, 16'h1);
    chk("R6 busy", rd_data, 16'h1000);
    @(negedge clk);
    chk("R6 pulse ends", {15'd0, sense_start}, 16'h0);
    cyc(1'b1, 16'h1000, 1'b0, 1'b0);
    chk("R6 no restart", {15'd0, sense_start}, 16'h0);
    chk("R6 still busy", rd_data, 16'h1000);
    cyc(1'b0, 16'h0, 1'b1, 1'b0);
    chk("R6/R2 done clears busy, sets cause 01", rd_data, 16'hA000);

    cyc(1'b1, 16'h8000, 1'b0, 1'b0);
    sense_supported = 1'b0;
    cyc(1'b1, 16'h1000, 1'b0, 1'b0);
    chk("R7 no pulse", {15'd0, sense_start}, 16'h0);
    chk("R7 bit12 zero", rd_data, 16'h0000);
    cyc(1'b1, 16'hFFFF, 1'b0, 1'b0);
    chk("R9 reserved", rd_data, 16'h080F);

    finish_run();
  end
endmodule